// File: doc/BRIEF.md
# Sequential Auto-Increment Display Loader

This block is the host-side write port of an eight-entry display memory. It is driven by a host strobe (`wr_n_i`, active low), a select line (`mode_i`) and a data bus. All three inputs are treated as asynchronous to the system clock. The block resynchronises them and acts on the trailing, rising edge of the strobe.

With the select line high, a strobe loads a four-bit control word taken from the upper nibble of the bus. The word holds four fields:

- run or shutdown;
- raw segments or decoded characters;
- hexadecimal or Code B character set;
- an arm flag announcing that display bytes follow.

With the select line low, a strobe stores the whole byte into the next memory location. The location is chosen by an internal pointer that starts at zero on every control word and steps by one per stored byte.

Writes are accepted only after an arming control word. Once every location has been filled, further byte strobes are ignored until the next control word, so a single location can never be patched alone. While a sequence is open, the block raises a blank request so the display stays dark. Scanning and character decoding sit downstream and take the control outputs and the memory write port.

Top module: `seq_disp_loader`

## Requirements
- R1: After reset, the four control outputs are 0, `blank_o` is 0 and `mem_we_o` is 0.
- R2: A strobe takes effect on the rising edge of `wr_n_i`. Its outputs change on the (SYNC_STAGES+1)-th rising clock edge after that edge. Holding or lowering `wr_n_i` has no effect.
- R3: A strobe with `mode_i` = 1 loads the control word from data bits 7..4, with this field assignment:
  - bit 4 drives `ctl_run_o` (1 = run, 0 = shutdown);
  - bit 5 drives `ctl_raw_o` (1 = no decode);
  - bit 6 drives `ctl_hex_o` (1 = hexadecimal, 0 = Code B);
  - bit 7 drives `ctl_coming_o` (1 = bytes follow).
  Data bits 3..0 have no effect.
- R4: A control word returns the pointer to location 0. It opens a new sequence exactly when its bit 7 is 1, and it aborts any sequence already open.
- R5: In an open sequence, a strobe with `mode_i` = 0 produces a one-cycle `mem_we_o` pulse. The pulse carries the full data byte on `mem_data_o` and the pointer value on `mem_addr_o`, and the pointer then advances by one. This holds in shutdown as well.
- R6: After DEPTH bytes have been stored, further byte strobes produce no `mem_we_o` until a new control word arrives.
- R7: Byte strobes made while no sequence is open produce no `mem_we_o`.
- R8: `blank_o` is 1 from the control word that opens a sequence until the byte for location DEPTH-1 is stored. It is 0 at all other times.
- R9: A control word never pulses `mem_we_o`, and byte strobes leave the control outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n_i | input | 1 | Host write strobe, active low, asynchronous |
| mode_i | input | 1 | 1 = control word, 0 = display byte |
| data_i | input | DATA_W | Host data bus |
| ctl_run_o | output | 1 | 1 = normal display, 0 = shutdown |
| ctl_raw_o | output | 1 | 1 = bytes drive segments directly |
| ctl_hex_o | output | 1 | 1 = hexadecimal set, 0 = Code B set |
| ctl_coming_o | output | 1 | Arm flag of the last control word |
| mem_we_o | output | 1 | Memory write pulse |
| mem_addr_o | output | $clog2(DEPTH) | Memory write location |
| mem_data_o | output | DATA_W | Memory write byte |
| blank_o | output | 1 | Blank request while a sequence is loading |

## Verification
The bench builds the block with DEPTH = 8, DATA_W = 8 and SYNC_STAGES = 3. The deeper-than-default synchroniser makes the exact edge count of R2 visible: one stage more than the minimum shows whether the latency tracks the parameter. Eight locations bring the full fill, the overflow beyond the last location and a mid-sequence restart within a few dozen strobes. The byte patterns are chosen so that every bit of `mem_data_o` toggles.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
   localparam int unsigned CTL_W   = 4;
   localparam int unsigned CTL_LSB = 4;

   // field order follows the host bus: bit 7 down to bit 4
   typedef struct packed {
      logic coming;
      logic hex;
      logic raw;
      logic run;
   } sdl_ctl_t;

   localparam sdl_ctl_t CTL_RST = '0;
endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [STAGES-1:0][W-1:0] stg_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sdl_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= {STAGES{RST_VAL}};
      end else begin
         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdl_edge.sv
module sdl_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic rise_o
);
   logic prev_q;

   // idle level of the strobe is high, so no edge is seen out of reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= level_i;
   end

   assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/sdl_ctl_reg.sv
module sdl_ctl_reg
   import sdl_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     load_i,
   input  sdl_ctl_t word_i,
   output sdl_ctl_t ctl_o
);
   sdl_ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= CTL_RST;
      else if (load_i) ctl_q <= word_i;
   end

   assign ctl_o = ctl_q;
endmodule

// File: rtl/sdl_seq_ptr.sv
module sdl_seq_ptr #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic              arm_i,
   input  logic              store_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              we_o,
   output logic [AW-1:0]     addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              open_o
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [AW-1:0]     ptr_q;
   logic              open_q;
   logic              we_q;
   logic [AW-1:0]     addr_q;
   logic [DATA_W-1:0] dat_q;
   logic              at_last;

   assign at_last = (ptr_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         open_q <= 1'b0;
         we_q   <= 1'b0;
         addr_q <= '0;
         dat_q  <= '0;
      end else begin
         we_q <= 1'b0;
         if (restart_i) begin
            ptr_q  <= '0;
            open_q <= arm_i;
         end else if (store_i && open_q) begin
            we_q   <= 1'b1;
            addr_q <= ptr_q;
            dat_q  <= data_i;
            if (at_last) begin
               ptr_q  <= '0;
               open_q <= 1'b0;
            end else begin
               ptr_q <= ptr_q + AW'(1);
            end
         end
      end
   end

   assign we_o   = we_q;
   assign addr_o = addr_q;
   assign data_o = dat_q;
   assign open_o = open_q;
endmodule

// File: rtl/seq_disp_loader.sv
module seq_disp_loader
   import sdl_pkg::*;
#(
   parameter int unsigned DEPTH       = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n_i,
   input  logic              mode_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              ctl_run_o,
   output logic              ctl_raw_o,
   output logic              ctl_hex_o,
   output logic              ctl_coming_o,
   output logic              mem_we_o,
   output logic [AW-1:0]     mem_addr_o,
   output logic [DATA_W-1:0] mem_data_o,
   output logic              blank_o
);
   localparam int unsigned BW = DATA_W + 2;
   localparam logic [BW-1:0] BUN_RST = BW'(1) << (BW - 1);

   generate
      if (DATA_W < CTL_LSB + CTL_W) begin : g_bad_width
         $error("seq_disp_loader: bus too narrow for the control nibble");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("seq_disp_loader: DEPTH must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("seq_disp_loader: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [BW-1:0]     bun_s;
   logic              wr_n_s;
   logic              mode_s;
   logic [DATA_W-1:0] data_s;
   logic              commit;
   logic              ctl_load;
   logic              byte_store;
   sdl_ctl_t          word;
   sdl_ctl_t          ctl;

   // strobe, select and bus travel through the same chain so they stay aligned
   sdl_sync #(
      .W      (BW),
      .STAGES (SYNC_STAGES),
      .RST_VAL(BUN_RST)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  ({wr_n_i, mode_i, data_i}),
      .q_o  (bun_s)
   );

   assign {wr_n_s, mode_s, data_s} = bun_s;

   sdl_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .level_i(wr_n_s),
      .rise_o (commit)
   );

   assign ctl_load   = commit &  mode_s;
   assign byte_store = commit & ~mode_s;
   assign word       = sdl_ctl_t'(data_s[CTL_LSB +: CTL_W]);

   sdl_ctl_reg u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(ctl_load),
      .word_i(word),
      .ctl_o (ctl)
   );

   sdl_seq_ptr #(
      .DEPTH (DEPTH),
      .DATA_W(DATA_W)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart_i(ctl_load),
      .arm_i    (word.coming),
      .store_i  (byte_store),
      .data_i   (data_s),
      .we_o     (mem_we_o),
      .addr_o   (mem_addr_o),
      .data_o   (mem_data_o),
      .open_o   (blank_o)
   );

   assign ctl_run_o    = ctl.run;
   assign ctl_raw_o    = ctl.raw;
   assign ctl_hex_o    = ctl.hex;
   assign ctl_coming_o = ctl.coming;
endmodule

// File: rtl/sdl_chk.sv
module sdl_chk #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_we_o,
   input logic [AW-1:0] mem_addr_o,
   input logic          blank_o,
   input logic [3:0]    ctl_bits
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [AW-1:0] prev_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        prev_addr_q <= '0;
      else if (mem_we_o) prev_addr_q <= mem_addr_o;
   end

   // R5: a store is a single-cycle pulse
   a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> !mem_we_o);

   // R5: a non-zero location follows directly on the one before
   a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && mem_addr_o != '0) |-> (mem_addr_o == prev_addr_q + AW'(1)));

   // R6: no location beyond the last one is ever addressed
   a_r6_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (mem_addr_o <= LAST));

   // R7: stores only under an arming control word
   a_r7_we_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> ctl_bits[3]);

   // R8: a store happens only while blank was requested
   a_r8_we_while_blank: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> $past(blank_o));

   // R8: blank ends on the last store or on a disarming control word
   a_r8_blank_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(blank_o) |-> ((mem_we_o && mem_addr_o == LAST) || !ctl_bits[3]));

   // R9: byte stores leave the control outputs alone
   a_r9_ctl_stable: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> $stable(ctl_bits));
endmodule

bind seq_disp_loader sdl_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_we_o  (mem_we_o),
   .mem_addr_o(mem_addr_o),
   .blank_o   (blank_o),
   .ctl_bits  ({ctl_coming_o, ctl_hex_o, ctl_raw_o, ctl_run_o})
);

// File: tb/seq_disp_loader_tb_top.sv
module seq_disp_loader_tb_top;
   localparam int unsigned DEPTH = 8;
   localparam int unsigned DW    = 8;
   localparam int unsigned S     = 3;
   localparam int unsigned AW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_n = 1'b1;
   logic          mode = 1'b0;
   logic [DW-1:0] data = '0;
   logic          run, raw, hex, coming, we, blank;
   logic [AW-1:0] addr;
   logic [DW-1:0] mdat;

   int            total = 0;
   int            bad = 0;
   bit            done = 1'b0;

   int            log_n = 0;
   logic [AW-1:0] log_a [64];
   logic [DW-1:0] log_d [64];

   always #2 clk = ~clk;

   seq_disp_loader #(.DEPTH(DEPTH), .DATA_W(DW), .SYNC_STAGES(S)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_n_i(wr_n), .mode_i(mode), .data_i(data),
      .ctl_run_o(run), .ctl_raw_o(raw), .ctl_hex_o(hex), .ctl_coming_o(coming),
      .mem_we_o(we), .mem_addr_o(addr), .mem_data_o(mdat), .blank_o(blank)
   );

   always @(negedge clk) begin
      if (rst_n && we) begin
         if (log_n < 64) begin
            log_a[log_n] = addr;
            log_d[log_n] = mdat;
         end
         log_n = log_n + 1;
      end
   end

   function automatic logic [DW-1:0] pat(input int i);
      return DW'((i * 8'h5B) ^ 8'hC3);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int ctl_now();
      return {28'd0, coming, hex, raw, run};
   endfunction

   task automatic host_wr(input logic m, input logic [DW-1:0] d);
      @(negedge clk);
      mode = m; data = d; wr_n = 1'b0;
      repeat (S + 2) @(negedge clk);
      wr_n = 1'b1;
      repeat (S + 3) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 ctl", ctl_now(), 0);
      chk("R1 blank", int'(blank), 0);
      chk("R1 we", int'(we), 0);
   endtask

   task automatic t_latency();
      @(negedge clk);
      mode = 1'b1; data = 8'hD0; wr_n = 1'b0;
      repeat (S + 2) @(negedge clk);
      chk("R2 no effect while low", ctl_now(), 0);
      wr_n = 1'b1;
      for (int i = 1; i <= int'(S); i++) begin
         @(negedge clk);
         chk("R2 early", ctl_now(), 0);
      end
      @(negedge clk);
      chk("R2 on time", ctl_now(), 4'hD);
      chk("R8 blank opens", int'(blank), 1);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_ctl_fields();
      int n0;
      n0 = log_n;
      host_wr(1'b1, 8'h7A);
      chk("R3 fields 7", ctl_now(), 4'h7);
      chk("R8 blank off unarmed", int'(blank), 0);
      host_wr(1'b1, 8'h25);
      chk("R3 fields 2", ctl_now(), 4'h2);
      host_wr(1'b1, 8'h2F);
      chk("R3 low nibble ignored", ctl_now(), 4'h2);
      chk("R3 run", int'(run), 0);
      chk("R9 no store on ctl", log_n - n0, 0);
   endtask

   task automatic t_fill();
      log_n = 0;
      host_wr(1'b1, 8'h80);
      chk("R8 blank armed", int'(blank), 1);
      for (int i = 0; i < int'(DEPTH); i++) begin
         host_wr(1'b0, pat(i));
         chk("R8 blank during fill", int'(blank), (i == int'(DEPTH) - 1) ? 0 : 1);
      end
      chk("R5 store count", log_n, DEPTH);
      for (int i = 0; i < int'(DEPTH); i++) begin
         chk("R5 addr", int'(log_a[i]), i);
         chk("R5 byte", int'(log_d[i]), int'(pat(i)));
      end
      chk("R9 ctl kept", ctl_now(), 4'h8);
   endtask

   task automatic t_overflow();
      host_wr(1'b0, 8'h3C);
      host_wr(1'b0, 8'hE1);
      chk("R6 extra ignored", log_n, DEPTH);
      chk("R6 blank stays off", int'(blank), 0);
      host_wr(1'b1, 8'h80);
      host_wr(1'b0, 8'h99);
      chk("R6 count after rearm", log_n, DEPTH + 1);
      chk("R4 rearm at 0", int'(log_a[DEPTH]), 0);
      chk("R4 rearm byte", int'(log_d[DEPTH]), 8'h99);
   endtask

   task automatic t_restart();
      log_n = 0;
      host_wr(1'b1, 8'hC0);
      for (int i = 0; i < 3; i++) host_wr(1'b0, pat(i + 10));
      host_wr(1'b1, 8'hC0);
      chk("R4 blank after restart", int'(blank), 1);
      host_wr(1'b0, 8'h5A);
      host_wr(1'b0, 8'hA5);
      chk("R4 count", log_n, 5);
      chk("R4 addr 3", int'(log_a[3]), 0);
      chk("R4 addr 4", int'(log_a[4]), 1);
      chk("R4 byte 4", int'(log_d[4]), 8'hA5);
   endtask

   task automatic t_disarm();
      log_n = 0;
      host_wr(1'b1, 8'h70);
      for (int i = 0; i < 3; i++) host_wr(1'b0, 8'hFF);
      chk("R7 unarmed no store", log_n, 0);
      chk("R7 blank", int'(blank), 0);
      host_wr(1'b1, 8'h80);
      host_wr(1'b0, 8'h01);
      host_wr(1'b0, 8'h02);
      host_wr(1'b1, 8'h00);
      chk("R4 disarm ends blank", int'(blank), 0);
      host_wr(1'b0, 8'h03);
      chk("R7 after disarm", log_n, 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_latency();
      t_ctl_fields();
      t_fill();
      t_overflow();
      t_restart();
      t_disarm();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule